// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This unit holds the counters a processor core uses for timekeeping. It has two independent 64-bit up-counters: a primary time base and an alternate time base. It also has a 32-bit down-counting decrementer and, optionally, a second decrementer reserved for a hypervisor. All of them advance on a shared `tick` qualifier. The `tbEnable` input freezes the two time bases but leaves the decrementers running. Software reaches every counter through one register port whose words are 32 bits wide. Each 64-bit counter appears there as two halves, and either half can be written without disturbing the other.

A decrementer raises its interrupt when its sign bit goes from clear to set. This happens in two ways: the counter steps from zero to all ones, or software writes a negative value over a non-negative one. Each interrupt line stays high until software acknowledges it. There is also a legacy clock view of the lower time-base word, which only exposes the bits under a fixed mask.

Top module: `tbdec_unit`

## Requirements
- R1: After reset both time bases read zero, both decrementers read 0xFFFFFFFF, and both interrupt outputs are low.
- R2: With `tick` and `tbEnable` both high, the primary time base grows by one per cycle, and the carry propagates from the low word (address 0) into the high word (address 1).
- R3: A write to address 0 replaces only the low word of the primary time base and keeps the high word. A write to address 1 replaces only the high word and keeps the low word.
- R4: The alternate time base is a separate 64-bit counter with the same counting and half-write rules. Its low word is at address 2 and its high word at address 3.
- R5: While `tbEnable` is low, both time bases hold their values. When `tbEnable` returns high, counting resumes from the held values.
- R6: The decrementer (address 4) drops by one on each cycle with `tick` high, regardless of `tbEnable`. Stepping from 0 gives 0xFFFFFFFF and sets `decIrq` on the next cycle.
- R7: A software write to address 4 sets `decIrq` only when bit 31 of the written value is 1 and bit 31 of the old value was 0.
- R8: Once set, an interrupt stays high until a write to address 7: bit 0 clears `decIrq` and bit 1 clears `hdecIrq`. If a new set event and an acknowledge fall in the same cycle, the set event wins.
- R9: The hypervisor decrementer (address 5) follows the R6 and R7 rules but drives only `hdecIrq`.
- R10: Address 6 is a masked view of the primary low word. A read returns the low word AND 0x3FFFFF80. A write stores the written value AND 0x3FFFFF80 into the low word and keeps the high word.
- R11: When a write to a counter and a tick fall in the same cycle, the counter takes the written value and skips that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count qualifier for all counters |
| tbEnable | input | 1 | Run enable for both time bases |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register select for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| decIrq | output | 1 | Decrementer interrupt, sticky |
| hdecIrq | output | 1 | Hypervisor decrementer interrupt, sticky |

## Verification
The bench builds the unit with its defaults: 32-bit words and the hypervisor decrementer present, so both interrupt lines and their separate acknowledge bits can be exercised. With the 32-bit word, preloading the low half near 0xFFFFFFFF lets the carry into the high half occur within a few ticks. It also makes the bit-31 sign rules of the decrementer reachable with small preload values. The reference model advances every cycle and checks the read port and both interrupts against it.

// File: rtl/tbdec_pkg.sv
`timescale 1ns/1ps
package tbdec_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_TB_LO  = 3'd0,
    SEL_TB_HI  = 3'd1,
    SEL_ALT_LO = 3'd2,
    SEL_ALT_HI = 3'd3,
    SEL_DEC    = 3'd4,
    SEL_HDEC   = 3'd5,
    SEL_RTC    = 3'd6,
    SEL_ACK    = 3'd7
  } regSel_e;

  typedef struct packed {
    logic tbLoWr;
    logic tbHiWr;
    logic rtcWr;
    logic altLoWr;
    logic altHiWr;
    logic decWr;
    logic hdecWr;
    logic decAck;
    logic hdecAck;
    logic tbRun;
    logic step;
  } strobe_t;
endpackage

// File: rtl/tbdec_ctrl.sv
`timescale 1ns/1ps
module tbdec_ctrl
  import tbdec_pkg::*;
(
  input  logic              tick,
  input  logic              tbEnable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ackBits,
  output strobe_t           strb
);
  regSel_e sel;
  assign sel = regSel_e'(addr);

  always_comb begin
    strb         = '0;
    strb.tbRun   = tick & tbEnable;
    strb.step    = tick;
    if (wrEn) begin
      unique case (sel)
        SEL_TB_LO:  strb.tbLoWr  = 1'b1;
        SEL_TB_HI:  strb.tbHiWr  = 1'b1;
        SEL_ALT_LO: strb.altLoWr = 1'b1;
        SEL_ALT_HI: strb.altHiWr = 1'b1;
        SEL_DEC:    strb.decWr   = 1'b1;
        SEL_HDEC:   strb.hdecWr  = 1'b1;
        SEL_RTC:    strb.rtcWr   = 1'b1;
        SEL_ACK: begin
          strb.decAck  = ackBits[0];
          strb.hdecAck = ackBits[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tbdec_downcnt.sv
`timescale 1ns/1ps
module tbdec_downcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         step,
  input  logic         wr,
  input  logic [W-1:0] wrVal,
  input  logic         ack,
  output logic [W-1:0] cnt,
  output logic         irq
);
  localparam int MSB = W - 1;

  logic setEv;
  assign setEv = wr ? (wrVal[MSB] & ~cnt[MSB]) : (step && (cnt == '0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '1;
      irq <= 1'b0;
    end else begin
      if (wr)        cnt <= wrVal;
      else if (step) cnt <= cnt - 1'b1;
      if (setEv)     irq <= 1'b1;
      else if (ack)  irq <= 1'b0;
    end
  end

  // R6: expiry wraps to all ones and raises the interrupt
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (step && !wr && cnt == '0) |=> (cnt == '1 && irq));

  // R7: a write crossing into negative raises the interrupt
  a_r7_write_edge: assert property (@(posedge clk) disable iff (!rstN)
    (wr && wrVal[MSB] && !cnt[MSB]) |=> irq);

  // R8: interrupt holds until acknowledged
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !ack) |=> irq);

  // R11: a write beats a tick in the same cycle
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    wr |=> (cnt == $past(wrVal)));
endmodule

// File: rtl/tbdec_datapath.sv
`timescale 1ns/1ps
module tbdec_datapath
  import tbdec_pkg::*;
#(
  parameter int          HALF_W   = 32,
  parameter bit          HYP_EN   = 1'b1,
  parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] rdData,
  output logic              decIrq,
  output logic              hdecIrq
);
  localparam int TB_W   = 2 * HALF_W;
  localparam int NUM_TB = 2;
  localparam logic [HALF_W-1:0] MASK_W = HALF_W'(RTC_MASK);

  logic [NUM_TB-1:0]             loWr, hiWr;
  logic [NUM_TB-1:0][HALF_W-1:0] loVal;
  logic [NUM_TB-1:0][TB_W-1:0]   tbq;

  assign loWr     = {strb.altLoWr, strb.tbLoWr | strb.rtcWr};
  assign hiWr     = {strb.altHiWr, strb.tbHiWr};
  assign loVal[0] = strb.rtcWr ? (wrData & MASK_W) : wrData;
  assign loVal[1] = wrData;

  for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
    always_ff @(posedge clk) begin
      if (!rstN)           tbq[g] <= '0;
      else if (loWr[g])    tbq[g] <= {tbq[g][TB_W-1:HALF_W], loVal[g]};
      else if (hiWr[g])    tbq[g] <= {wrData, tbq[g][HALF_W-1:0]};
      else if (strb.tbRun) tbq[g] <= tbq[g] + 1'b1;
    end

    // R5: frozen time base holds its value
    a_r5_freeze: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.tbRun && !loWr[g] && !hiWr[g]) |=> $stable(tbq[g]));
    // R3: low-half write keeps the high half
    a_r3_keep_hi: assert property (@(posedge clk) disable iff (!rstN)
      loWr[g] |=> (tbq[g][TB_W-1:HALF_W] == $past(tbq[g][TB_W-1:HALF_W])));
    // R3: high-half write keeps the low half
    a_r3_keep_lo: assert property (@(posedge clk) disable iff (!rstN)
      hiWr[g] |=> (tbq[g][HALF_W-1:0] == $past(tbq[g][HALF_W-1:0])));
    // R2: running time base counts by one
    a_r2_count: assert property (@(posedge clk) disable iff (!rstN)
      (strb.tbRun && !loWr[g] && !hiWr[g]) |=> (tbq[g] == $past(tbq[g]) + 1'b1));
  end

  logic [HALF_W-1:0] decCnt, hdecCnt;

  tbdec_downcnt #(.W(HALF_W)) u_dec (
    .clk   (clk),
    .rstN  (rstN),
    .step  (strb.step),
    .wr    (strb.decWr),
    .wrVal (wrData),
    .ack   (strb.decAck),
    .cnt   (decCnt),
    .irq   (decIrq)
  );

  if (HYP_EN) begin : g_hyp
    tbdec_downcnt #(.W(HALF_W)) u_hdec (
      .clk   (clk),
      .rstN  (rstN),
      .step  (strb.step),
      .wr    (strb.hdecWr),
      .wrVal (wrData),
      .ack   (strb.hdecAck),
      .cnt   (hdecCnt),
      .irq   (hdecIrq)
    );
  end else begin : g_nohyp
    assign hdecCnt = '0;
    assign hdecIrq = 1'b0;
  end

  always_comb begin
    unique case (regSel_e'(addr))
      SEL_TB_LO:  rdData = tbq[0][HALF_W-1:0];
      SEL_TB_HI:  rdData = tbq[0][TB_W-1:HALF_W];
      SEL_ALT_LO: rdData = tbq[1][HALF_W-1:0];
      SEL_ALT_HI: rdData = tbq[1][TB_W-1:HALF_W];
      SEL_DEC:    rdData = decCnt;
      SEL_HDEC:   rdData = hdecCnt;
      SEL_RTC:    rdData = tbq[0][HALF_W-1:0] & MASK_W;
      default:    rdData = '0;
    endcase
  end

  // R10: the masked view never shows bits outside the mask
  a_r10_mask: assert property (@(posedge clk) disable iff (!rstN)
    (addr == SEL_RTC) |-> ((rdData & ~MASK_W) == '0));
endmodule

// File: rtl/tbdec_unit.sv
`timescale 1ns/1ps
module tbdec_unit
  import tbdec_pkg::*;
#(
  parameter int          HALF_W   = 32,
  parameter bit          HYP_EN   = 1'b1,
  parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              tbEnable,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] rdData,
  output logic              decIrq,
  output logic              hdecIrq
);
  strobe_t strb;

  tbdec_ctrl u_ctrl (
    .tick     (tick),
    .tbEnable (tbEnable),
    .wrEn     (wrEn),
    .addr     (addr),
    .ackBits  (wrData[1:0]),
    .strb     (strb)
  );

  tbdec_datapath #(
    .HALF_W   (HALF_W),
    .HYP_EN   (HYP_EN),
    .RTC_MASK (RTC_MASK)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .decIrq  (decIrq),
    .hdecIrq (hdecIrq)
  );
endmodule

// File: tb/tbdec_unit_tb.sv
`timescale 1ns/1ps
module tbdec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        tbEnable = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] rdData;
  logic        decIrq, hdecIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam bit [31:0] MASK = 32'h3FFF_FF80;

  bit [63:0] mTb = 0, mAlt = 0;
  bit [31:0] mDec = 32'hFFFF_FFFF, mHdec = 32'hFFFF_FFFF;
  bit        mDi = 0, mHi = 0;

  always #2 clk = ~clk;

  tbdec_unit dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .tbEnable(tbEnable),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .decIrq(decIrq), .hdecIrq(hdecIrq)
  );

  function automatic bit [31:0] mRead(input bit [2:0] a);
    case (a)
      3'd0: return mTb[31:0];
      3'd1: return mTb[63:32];
      3'd2: return mAlt[31:0];
      3'd3: return mAlt[63:32];
      3'd4: return mDec;
      3'd5: return mHdec;
      3'd6: return mTb[31:0] & MASK;
      default: return 32'd0;
    endcase
  endfunction

  task automatic decModel(inout bit [31:0] c, inout bit irq,
                          input bit tk, input bit w, input bit [31:0] d, input bit ak);
    bit s;
    if (w) begin s = d[31] && !c[31]; c = d; end
    else if (tk) begin s = (c == 0); c = c - 1; end
    else s = 0;
    if (s) irq = 1; else if (ak) irq = 0;
  endtask

  task automatic model(input bit tk, input bit en, input bit w,
                       input bit [2:0] a, input bit [31:0] d);
    if (w && a == 0)      mTb = {mTb[63:32], d};
    else if (w && a == 1) mTb = {d, mTb[31:0]};
    else if (w && a == 6) mTb = {mTb[63:32], d & MASK};
    else if (tk && en)    mTb = mTb + 1;
    if (w && a == 2)      mAlt = {mAlt[63:32], d};
    else if (w && a == 3) mAlt = {d, mAlt[31:0]};
    else if (tk && en)    mAlt = mAlt + 1;
    decModel(mDec,  mDi, tk, w && a == 4, d, w && a == 7 && d[0]);
    decModel(mHdec, mHi, tk, w && a == 5, d, w && a == 7 && d[1]);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "rdData", rdData, mRead(addr));
    chk(tag, "decIrq", {31'd0, decIrq}, {31'd0, mDi});
    chk(tag, "hdecIrq", {31'd0, hdecIrq}, {31'd0, mHi});
  endtask

  task automatic step(input string tag, input bit tk, input bit en, input bit w,
                      input bit [2:0] a, input bit [31:0] d);
    tick = tk; tbEnable = en; wrEn = w; addr = a; wrData = d;
    @(posedge clk);
    model(tk, en, w, a, d);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic rd(input string tag, input bit [2:0] a, input bit en);
    step(tag, 1'b0, en, 1'b0, a, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #0;
    // R1: reset values through the read port
    for (int a = 0; a < 7; a++) begin
      addr = 3'(a);
      #0.1;
      compareAll("R1");
    end
    // R2: counting with carry
    for (int i = 0; i < 10; i++) step("R2", 1, 1, 0, 3'd0, 0);
    step("R3", 0, 1, 1, 3'd0, 32'hFFFF_FFF8);
    for (int i = 0; i < 12; i++) step("R2", 1, 1, 0, (i % 2 == 0) ? 3'd1 : 3'd0, 0);
    // R3: half writes keep the other half
    step("R3", 1, 1, 1, 3'd1, 32'h1234_5678);
    rd("R3", 3'd0, 1); rd("R3", 3'd1, 1);
    step("R3", 0, 1, 1, 3'd0, 32'h0000_00AA);
    rd("R3", 3'd1, 1);
    // R4: alternate time base
    step("R4", 0, 1, 1, 3'd2, 32'hFFFF_FFFE);
    step("R4", 0, 1, 1, 3'd3, 32'h0000_0007);
    for (int i = 0; i < 6; i++) step("R4", 1, 1, 0, (i % 2 == 0) ? 3'd2 : 3'd3, 0);
    rd("R4", 3'd0, 1);
    // R5: freeze and resume
    for (int i = 0; i < 8; i++) step("R5", 1, 0, 0, 3'(i % 4), 0);
    for (int i = 0; i < 4; i++) step("R5", 1, 1, 0, 3'(i % 4), 0);
    // R6: decrementer counts down and wraps
    step("R6", 0, 1, 1, 3'd4, 32'd3);
    for (int i = 0; i < 6; i++) step("R6", 1, 0, 0, 3'd4, 0);
    // R8: sticky, then cleared by acknowledge
    for (int i = 0; i < 3; i++) step("R8", 1, 1, 0, 3'd4, 0);
    step("R8", 0, 1, 1, 3'd7, 32'd1);
    rd("R8", 3'd4, 1);
    // R7: writes that cross into negative and ones that do not
    step("R7", 0, 1, 1, 3'd4, 32'h7FFF_FFFF);
    step("R7", 0, 1, 1, 3'd4, 32'h8000_0000);
    step("R7", 0, 1, 1, 3'd7, 32'd1);
    step("R7", 0, 1, 1, 3'd4, 32'h9000_0000);
    step("R7", 0, 1, 1, 3'd4, 32'd5);
    rd("R7", 3'd4, 1);
    // R8: set and acknowledge in the same cycle
    step("R8", 0, 1, 1, 3'd4, 32'd0);
    step("R8", 1, 1, 1, 3'd7, 32'd1);
    rd("R8", 3'd4, 1);
    step("R8", 0, 1, 1, 3'd7, 32'd1);
    // R11: write beats tick
    step("R11", 1, 1, 1, 3'd4, 32'd100);
    step("R11", 1, 1, 1, 3'd0, 32'h0000_0050);
    step("R11", 1, 1, 1, 3'd2, 32'h0000_0020);
    rd("R11", 3'd2, 1);
    // R9: hypervisor decrementer on its own line
    step("R9", 0, 1, 1, 3'd5, 32'd1);
    for (int i = 0; i < 4; i++) step("R9", 1, 1, 0, 3'd5, 0);
    step("R9", 0, 1, 1, 3'd7, 32'd2);
    step("R9", 0, 1, 1, 3'd5, 32'h8000_0001);
    step("R9", 0, 1, 1, 3'd7, 32'd3);
    // R10: masked legacy view
    step("R10", 0, 1, 1, 3'd1, 32'hCAFE_0001);
    step("R10", 0, 1, 1, 3'd6, 32'hFFFF_FFFF);
    rd("R10", 3'd0, 1); rd("R10", 3'd1, 1);
    for (int i = 0; i < 200; i++) step("R10", 1, 1, 0, 3'd6, 0);
    rd("R10", 3'd0, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule